// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block connects a simple single-word host request port to a 16-bit single-data-rate synchronous DRAM with four banks. After reset it brings the memory up on its own: it waits out a power-up count, closes every bank, issues eight auto-refresh commands, and then writes the mode register with the selected CAS latency. Only then does it accept host requests.

Each accepted request is served with a closed-page policy. The block opens the row, then issues a single-beat read or write with auto-precharge (A10 high), and then waits until the bank has recovered before it issues anything else. Write data and its byte mask go out in the same cycle as the write command. Read data is captured CAS-latency cycles after the device samples the read, and is returned with a one-cycle valid pulse.

A free-running interval timer requests a refresh. Once the current access has finished, the refresh is served ahead of any waiting host request: a precharge-all, then an auto-refresh, then a quiet period of tRC. Every spacing between commands is a parameter counted in clock cycles. Clock enable is held high and chip select is held low.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset is released, the pins carry only NOP for POWERUP_CYC cycles, and `req_ready` stays low until initialisation has finished.
- R2: Initialisation issues, in this order: one precharge with A10=1, then INIT_REFS (8) auto-refresh commands, then one mode-register set. No mode-register set is issued after that.
- R3: The mode-register word is as follows. A2..A0=000 selects burst length one. A3=0 selects sequential order. A6..A4 is 3 when `cas_lat_3` is high and 2 when it is low. A11..A7 are zero and the bank bits are zero. The latency in force is the one programmed.
- R4: Commands use {ras_n,cas_n,we_n} with these codes: ACT 011, READ 101, WRITE 100, PRECHARGE 010, REFRESH 001, MODE 000, NOP 111. `sd_cs_n` is low and `sd_cke` is high.
- R5: An accepted request produces ACT with the request's bank and row. Exactly T_RCD cycles later it produces READ or WRITE to the same bank with A7..A0 = column, A10=1, and A11, A9, A8 = 0.
- R6: In the WRITE cycle, `sd_dq_oe` is high, `sd_dq_out` holds the write data and `sd_dqm` = ~`req_be` (bit 1 = upper byte). In every other cycle, `sd_dq_oe` and `sd_dqm` are zero.
- R7: For a READ in cycle c, the block samples `sd_dq_in` at the end of cycle c+CL. It then raises `rsp_valid` for exactly cycle c+CL+1, with that word on `rsp_rdata`.
- R8: Minimum gaps between commands, in cycles: after PRECHARGE T_RP; after REFRESH T_RC; after MODE T_MRD; after READ max(1+T_RP, 4, T_RC-T_RCD); after WRITE max(T_WR+T_RP, T_RC-T_RCD).
- R9: A refresh falls due every REFI_CYC cycles. It is served before a waiting host request, as PRECHARGE with A10=1 followed by REFRESH. Consecutive refreshes therefore stay within a few cycles of REFI_CYC.
- R10: `req_ready` is high only while the block is idle and no refresh is due. A request is taken only on `req_valid && req_ready`, and only one request is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cas_lat_3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 (taken at mode set) |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken this cycle if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | 2 | Bank |
| req_row | input | 12 | Row |
| req_col | input | 8 | Column |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Address |
| sd_dqm | output | 2 | Byte mask |
| sd_dq_out | output | 16 | Data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The bench builds the block with POWERUP_CYC=30, T_RCD=3, T_RP=2, T_RC=6, T_WR=3, T_MRD=2 and REFI_CYC=150. With these values, the precharge and mode gaps fall to their two-cycle minimum, read recovery is set by the CAS-latency bus rule, and write recovery is set by T_WR+T_RP. With a short refresh interval, refreshes fall due in the middle of back-to-back host traffic within a few hundred cycles. The bench applies reset twice, once with each CAS latency, so both capture taps and both mode words are exercised.

// File: rtl/sdram_seq_pkg.sv
// Shared widths, command codes and controller phases for the SDRAM sequencer.
package sdram_seq_pkg;
    localparam int BA_W  = 2;
    localparam int ROW_W = 12;
    localparam int COL_W = 8;
    localparam int DQ_W  = 16;
    localparam int BE_W  = DQ_W / 8;
    localparam int MAX_CL = 3;

    // {ras_n, cas_n, we_n} with chip select low
    typedef enum logic [2:0] {
        CMD_MODE = 3'b000,
        CMD_REFR = 3'b001,
        CMD_PRE  = 3'b010,
        CMD_ACT  = 3'b011,
        CMD_WR   = 3'b100,
        CMD_RD   = 3'b101,
        CMD_NOP  = 3'b111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        PH_GAP, PH_PREALL, PH_REFR, PH_MODE, PH_IDLE, PH_XFER
    } phase_e;

    typedef struct packed {
        logic             we;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [DQ_W-1:0]  wdata;
        logic [BE_W-1:0]  be;
    } host_req_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sdram_gap_timer.sv
// Down-counter that holds the command bus quiet between commands.
// Assumes: a load only happens once the previous count has expired.
module sdram_gap_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // count down to zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= W'(RST_VAL);
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R8: a new gap never starts while one is still running
    a_r8_load_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> done);
endmodule

// File: rtl/sdram_refresh_timer.sv
// Raises a refresh request every PERIOD cycles; the request is held until acknowledged.
// Assumes: PERIOD is far larger than the time taken to serve a refresh.
module sdram_refresh_timer #(
    parameter int PERIOD = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(PERIOD);
    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == '0);

    // free-running interval counter
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= CW'(PERIOD - 1);
        else if (tick) cnt <= CW'(PERIOD - 1);
        else           cnt <= cnt - 1'b1;
    end

    // sticky request flag, set on tick, cleared on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (tick) pend <= 1'b1;
        else if (ack)  pend <= 1'b0;
    end

    // R9: a due refresh is not dropped until it is served
    a_r9_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);
endmodule

// File: rtl/sdram_rd_capture.sv
// Delays a read marker by the CAS latency and captures the data bus at that point.
// Assumes: lat is 2 or 3 and stays fixed while reads are in flight.
module sdram_rd_capture
    import sdram_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_rd,
    input  logic [1:0]      lat,
    input  logic [DQ_W-1:0] dq_in,
    output logic            rsp_valid,
    output logic [DQ_W-1:0] rsp_rdata
);
    logic [MAX_CL:0] pipe;

    // shift the read marker one stage per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[MAX_CL-1:0], issue_rd};
    end

    // sample the bus when the marker reaches the selected latency tap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= pipe[lat];
            if (pipe[lat]) rsp_rdata <= dq_in;
        end
    end

    // R7: every read yields a single one-cycle response
    a_r7_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sdram_seq_ctrl.sv
// SDRAM command sequencer: power-up initialisation, closed-page single-word
// accesses with auto-precharge, and interval refresh with priority over hosts.
// Assumes: every timing parameter is at least 2 cycles, and POWERUP_CYC is the
// largest count.
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int POWERUP_CYC = 20000,
    parameter int T_RCD       = 3,
    parameter int T_RP        = 3,
    parameter int T_RC        = 7,
    parameter int T_WR        = 2,
    parameter int T_MRD       = 2,
    parameter int REFI_CYC    = 1562,
    parameter int INIT_REFS   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cas_lat_3,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [DQ_W-1:0]  req_wdata,
    input  logic [BE_W-1:0]  req_be,
    output logic             rsp_valid,
    output logic [DQ_W-1:0]  rsp_rdata,
    output logic             sd_cke,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr,
    output logic [BE_W-1:0]  sd_dqm,
    output logic [DQ_W-1:0]  sd_dq_out,
    output logic             sd_dq_oe,
    input  logic [DQ_W-1:0]  sd_dq_in
);
    localparam int RD_REC  = imax(imax(1 + T_RP, MAX_CL + 1), T_RC - T_RCD);
    localparam int WR_REC  = imax(T_WR + T_RP, T_RC - T_RCD);
    localparam int GAP_MAX = imax(POWERUP_CYC, imax(T_RC, imax(RD_REC, WR_REC)));
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int IR_W    = $clog2(INIT_REFS + 1);
    localparam int A_AP    = 10;

    phase_e           phase, phase_nx, after, after_nx;
    sd_cmd_e          cmd_q, cmd_nx;
    logic [BA_W-1:0]  ba_nx;
    logic [ROW_W-1:0] addr_nx;
    logic [BE_W-1:0]  dqm_nx;
    logic [DQ_W-1:0]  dqo_nx;
    logic             oe_nx;
    logic             gap_load, gap_done;
    logic [GAP_W-1:0] gap_val;
    logic             ref_pend, ref_ack, rd_issue, accept, mode_wr;
    logic             in_init, cl3_q;
    logic [IR_W-1:0]  init_left;
    host_req_t        req_q;

    assign req_ready = (phase == PH_IDLE) && !ref_pend;
    assign sd_cke    = 1'b1;
    assign sd_cs_n   = 1'b0;
    assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

    sdram_gap_timer #(.W(GAP_W), .RST_VAL(POWERUP_CYC - 1)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .done(gap_done)
    );

    sdram_refresh_timer #(.PERIOD(REFI_CYC)) u_refi (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
    );

    sdram_rd_capture u_cap (
        .clk(clk), .rst_n(rst_n), .issue_rd(rd_issue),
        .lat(cl3_q ? 2'd3 : 2'd2), .dq_in(sd_dq_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // choose the command for the next cycle and the gap that must follow it
    always_comb begin
        cmd_nx   = CMD_NOP;
        ba_nx    = '0;
        addr_nx  = '0;
        dqm_nx   = '0;
        dqo_nx   = '0;
        oe_nx    = 1'b0;
        phase_nx = phase;
        after_nx = after;
        gap_load = 1'b0;
        gap_val  = '0;
        ref_ack  = 1'b0;
        rd_issue = 1'b0;
        accept   = 1'b0;
        mode_wr  = 1'b0;
        unique case (phase)
            PH_GAP: begin
                if (gap_done) phase_nx = after;
            end
            PH_PREALL, PH_IDLE: begin
                if (phase == PH_PREALL || ref_pend) begin
                    cmd_nx        = CMD_PRE;
                    addr_nx[A_AP] = 1'b1;
                    gap_load      = 1'b1;
                    gap_val       = GAP_W'(T_RP - 2);
                    phase_nx      = PH_GAP;
                    after_nx      = PH_REFR;
                end else if (req_valid) begin
                    accept   = 1'b1;
                    cmd_nx   = CMD_ACT;
                    ba_nx    = req_bank;
                    addr_nx  = req_row;
                    gap_load = 1'b1;
                    gap_val  = GAP_W'(T_RCD - 2);
                    phase_nx = PH_GAP;
                    after_nx = PH_XFER;
                end
            end
            PH_REFR: begin
                cmd_nx   = CMD_REFR;
                ref_ack  = 1'b1;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_RC - 2);
                phase_nx = PH_GAP;
                if (!in_init)                   after_nx = PH_IDLE;
                else if (init_left > IR_W'(1))  after_nx = PH_REFR;
                else                            after_nx = PH_MODE;
            end
            PH_MODE: begin
                cmd_nx       = CMD_MODE;
                addr_nx[6:4] = cas_lat_3 ? 3'd3 : 3'd2;
                mode_wr      = 1'b1;
                gap_load     = 1'b1;
                gap_val      = GAP_W'(T_MRD - 2);
                phase_nx     = PH_GAP;
                after_nx     = PH_IDLE;
            end
            PH_XFER: begin
                ba_nx              = req_q.bank;
                addr_nx[COL_W-1:0] = req_q.col;
                addr_nx[A_AP]      = 1'b1;
                gap_load           = 1'b1;
                phase_nx           = PH_GAP;
                after_nx           = PH_IDLE;
                if (req_q.we) begin
                    cmd_nx  = CMD_WR;
                    dqo_nx  = req_q.wdata;
                    dqm_nx  = ~req_q.be;
                    oe_nx   = 1'b1;
                    gap_val = GAP_W'(WR_REC - 2);
                end else begin
                    cmd_nx   = CMD_RD;
                    rd_issue = 1'b1;
                    gap_val  = GAP_W'(RD_REC - 2);
                end
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    // sequencing state and registered pin drivers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_GAP;
            after     <= PH_PREALL;
            cmd_q     <= CMD_NOP;
            sd_ba     <= '0;
            sd_addr   <= '0;
            sd_dqm    <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
        end else begin
            phase     <= phase_nx;
            after     <= after_nx;
            cmd_q     <= cmd_nx;
            sd_ba     <= ba_nx;
            sd_addr   <= addr_nx;
            sd_dqm    <= dqm_nx;
            sd_dq_out <= dqo_nx;
            sd_dq_oe  <= oe_nx;
        end
    end

    // initialisation progress and the latency that was programmed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_init   <= 1'b1;
            init_left <= IR_W'(INIT_REFS);
            cl3_q     <= 1'b1;
        end else begin
            if (ref_ack && in_init) init_left <= init_left - 1'b1;
            if (mode_wr) begin
                in_init <= 1'b0;
                cl3_q   <= cas_lat_3;
            end
        end
    end

    // hold the accepted request for the column command
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= '0;
        else if (accept) req_q <= '{we: req_write, bank: req_bank, row: req_row,
                                    col: req_col, wdata: req_wdata, be: req_be};
    end

    // R1: no host traffic is taken while initialisation runs
    a_r1_init_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        in_init |-> !req_ready);
    // R10: a handshake opens the requested bank in the next cycle
    a_r10_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_q == CMD_ACT && sd_ba == $past(req_bank)));
    // R5: the row-to-column delay is never collapsed
    a_r5_act_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));
    // R6: the data bus is driven only with a write command
    a_r6_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd_q == CMD_WR));
    // R9: a refresh is followed by a quiet cycle
    a_r9_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REFR) |=> (cmd_q == CMD_NOP));
endmodule

// File: tb/sim_sdram_seq_ctrl.sv
// Bench: behavioural memory and host model, checked on every clock.
module sim_sdram_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int P_PWR = 30, P_RCD = 3, P_RP = 2, P_RC = 6, P_WR = 3, P_MRD = 2, P_REFI = 150;
    localparam int RD_REC = ((1 + P_RP > 4) ? 1 + P_RP : 4) > (P_RC - P_RCD)
                            ? ((1 + P_RP > 4) ? 1 + P_RP : 4) : (P_RC - P_RCD);
    localparam int WR_REC = (P_WR + P_RP > P_RC - P_RCD) ? P_WR + P_RP : P_RC - P_RCD;

    logic clk = 1'b0, rst_n = 1'b0, cas_lat_3 = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_bank = '0, req_be = '0;
    logic [11:0] req_row = '0;
    logic [7:0] req_col = '0;
    logic [15:0] req_wdata = '0, sd_dq_in = 16'hDEAD;
    logic req_ready, rsp_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [15:0] rsp_rdata, sd_dq_out;
    logic [1:0] sd_ba, sd_dqm;
    logic [11:0] sd_addr;

    sdram_seq_ctrl #(.POWERUP_CYC(P_PWR), .T_RCD(P_RCD), .T_RP(P_RP), .T_RC(P_RC),
                     .T_WR(P_WR), .T_MRD(P_MRD), .REFI_CYC(P_REFI), .INIT_REFS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cas_lat_3(cas_lat_3), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0, bad = 0;
    typedef struct { bit we; int bank; int row; int col; logic [15:0] data; logic [1:0] be; logic [15:0] exp; } hreq_t;
    typedef struct { int cyc; logic [15:0] val; } timed_t;
    hreq_t  pend_q[$];
    timed_t drive_q[$], rsp_q[$];
    logic [15:0] dram[int], shadow[int];
    int rel, init_step, last_cyc, last_ref, ref_posts, cl;
    logic [2:0] last_cmd;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int need(input logic [2:0] c);
        case (c)
            3'b010: return P_RP;
            3'b001: return P_RC;
            3'b000: return P_MRD;
            3'b011: return P_RCD;
            3'b101: return RD_REC;
            3'b100: return WR_REC;
            default: return 0;
        endcase
    endfunction

    function automatic int key(input int b, input int r, input int c);
        return b * (1 << 20) + r * 256 + c;
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] en);
        return {en[1] ? d[15:8] : old[15:8], en[0] ? d[7:0] : old[7:0]};
    endfunction

    // per-cycle reference model of the memory device and the expected pin behaviour
    always @(negedge clk) begin
        logic [2:0] c;
        if (!rst_n) begin
            chk(!req_ready, "R10 ready during reset", req_ready, 0);
            chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 NOP during reset", {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
            rel = -1; init_step = 0; last_cyc = -1; last_ref = -1; ref_posts = 0;
            last_cmd = 3'b111; cl = cas_lat_3 ? 3 : 2;
            pend_q.delete(); drive_q.delete(); rsp_q.delete();
            sd_dq_in = 16'hDEAD;
        end else begin
            rel++;
            c = {sd_ras_n, sd_cas_n, sd_we_n};
            if (drive_q.size() > 0 && drive_q[0].cyc == rel) sd_dq_in = drive_q.pop_front().val;
            else sd_dq_in = 16'hDEAD;
            if (rsp_q.size() > 0 && rsp_q[0].cyc == rel) begin
                chk(rsp_valid, "R7 response valid", rsp_valid, 1);
                chk(rsp_rdata == rsp_q[0].val, "R7 response data", rsp_rdata, rsp_q[0].val);
                void'(rsp_q.pop_front());
            end else chk(!rsp_valid, "R7 no stray response", rsp_valid, 0);
            if (init_step < 10) chk(!req_ready, "R1 ready low during init", req_ready, 0);
            if (!sd_dq_oe || c != 3'b100) begin
                if (c != 3'b100) chk(!sd_dq_oe && sd_dqm == 2'b00, "R6 bus idle off write", {sd_dq_oe, sd_dqm}, 0);
            end
            if (c != 3'b111) begin
                chk(!sd_cs_n && sd_cke, "R4 select and clock enable", {sd_cs_n, sd_cke}, 2'b01);
                if (last_cyc >= 0) chk(rel - last_cyc >= need(last_cmd), "R8 command gap", rel - last_cyc, need(last_cmd));
                if (init_step < 10) begin
                    if (init_step == 0) begin
                        chk(c == 3'b010 && sd_addr[10], "R2 first precharge-all", {c, sd_addr[10]}, 4'b0101);
                        chk(rel >= P_PWR - 1 && rel <= P_PWR + 1, "R1 power-up wait", rel, P_PWR);
                    end else if (init_step <= 8) begin
                        chk(c == 3'b001, "R2 init refresh", c, 3'b001);
                    end else begin
                        chk(c == 3'b000, "R2 mode set", c, 3'b000);
                        chk(sd_addr == {5'b0, cl == 3 ? 3'd3 : 3'd2, 4'b0} && sd_ba == 0, "R3 mode word",
                            sd_addr, {5'b0, cl == 3 ? 3'd3 : 3'd2, 4'b0});
                    end
                    init_step++;
                end else begin
                    case (c)
                        3'b011: begin
                            chk(pend_q.size() == 1, "R10 one request in flight", pend_q.size(), 1);
                            if (pend_q.size() > 0) begin
                                chk(sd_ba == pend_q[0].bank, "R5 activate bank", sd_ba, pend_q[0].bank);
                                chk(sd_addr == pend_q[0].row, "R5 activate row", sd_addr, pend_q[0].row);
                            end
                        end
                        3'b101, 3'b100: begin
                            chk(last_cmd == 3'b011 && rel - last_cyc == P_RCD, "R5 column after T_RCD", rel - last_cyc, P_RCD);
                            if (pend_q.size() > 0) begin
                                hreq_t f;
                                logic [15:0] old;
                                f = pend_q.pop_front();
                                chk((c == 3'b100) == f.we, "R5 direction", c, f.we ? 3'b100 : 3'b101);
                                chk(sd_ba == f.bank, "R5 column bank", sd_ba, f.bank);
                                chk(sd_addr == {4'b0100, 8'(f.col)}, "R5 column address", sd_addr, {4'b0100, 8'(f.col)});
                                old = dram.exists(key(f.bank, f.row, f.col)) ? dram[key(f.bank, f.row, f.col)] : 16'h0;
                                if (c == 3'b100) begin
                                    chk(sd_dq_oe, "R6 drive on write", sd_dq_oe, 1);
                                    chk(sd_dqm == ~f.be, "R6 write mask", sd_dqm, ~f.be);
                                    chk(sd_dq_out == f.data, "R6 write data", sd_dq_out, f.data);
                                    dram[key(f.bank, f.row, f.col)] = merge(old, sd_dq_out, ~sd_dqm);
                                end else begin
                                    drive_q.push_back('{rel + cl, old});
                                    rsp_q.push_back('{rel + cl + 1, f.exp});
                                end
                            end
                        end
                        3'b010: chk(sd_addr[10], "R9 precharge all banks", sd_addr[10], 1);
                        3'b001: begin
                            chk(last_cmd == 3'b010, "R9 precharge before refresh", last_cmd, 3'b010);
                            if (last_ref >= 0)
                                chk(rel - last_ref >= P_REFI - 12 && rel - last_ref <= P_REFI + 12,
                                    "R9 refresh interval", rel - last_ref, P_REFI);
                            last_ref = rel;
                            ref_posts++;
                        end
                        default: chk(0, "R2 no mode set after init", c, 3'b111);
                    endcase
                end
                last_cmd = c;
                last_cyc = rel;
            end
        end
    end

    task automatic do_req(input bit we, input int b, input int r, input int c, input logic [15:0] d, input logic [1:0] be);
        hreq_t h;
        int k;
        k = key(b, r, c);
        h.we = we; h.bank = b; h.row = r; h.col = c; h.data = d; h.be = be;
        h.exp = shadow.exists(k) ? shadow[k] : 16'h0;
        if (we) shadow[k] = merge(h.exp, d, be);
        req_valid = 1'b1; req_write = we; req_bank = 2'(b); req_row = 12'(r);
        req_col = 8'(c); req_wdata = d; req_be = be;
        forever begin
            if (req_ready) break;
            @(negedge clk); #1;
        end
        pend_q.push_back(h);
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic run_phase(input bit cl3);
        int rows[3] = '{0, 4095, 7};
        int cols[3] = '{0, 255, 12};
        @(negedge clk); #1;
        rst_n = 1'b0; cas_lat_3 = cl3;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        // R5 R6 R7: full write, byte-masked writes, read back
        do_req(1, 0, 0, 0, 16'h1234, 2'b11);
        do_req(0, 0, 0, 0, 16'h0, 2'b00);
        do_req(1, 0, 0, 0, 16'hABCD, 2'b01);
        do_req(0, 0, 0, 0, 16'h0, 2'b00);
        do_req(1, 0, 0, 0, 16'h5EEF, 2'b10);
        do_req(0, 0, 0, 0, 16'h0, 2'b00);
        do_req(1, 0, 0, 0, 16'hFFFF, 2'b00);
        do_req(0, 0, 0, 0, 16'h0, 2'b00);
        // boundary addresses and an unwritten location
        do_req(1, 3, 4095, 255, 16'hC0DE, 2'b11);
        do_req(0, 2, 9, 3, 16'h0, 2'b00);
        do_req(0, 3, 4095, 255, 16'h0, 2'b00);
        // back-to-back mixed traffic across banks, overlapping refreshes
        for (int i = 0; i < 60; i++) begin
            int sel;
            sel = int'($urandom % 9);
            do_req(($urandom % 2) == 1, int'($urandom % 4), rows[sel % 3], cols[sel / 3],
                   16'($urandom), 2'($urandom));
        end
        repeat (420) @(negedge clk);
        chk(ref_posts >= 4, "R9 refreshes issued", ref_posts, 4);
        chk(init_step == 10, "R2 init completed", init_step, 10);
    endtask

    initial begin
        run_phase(1'b1);
        run_phase(1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule